// File: doc/BRIEF.md
# Timed Command Sample Tagger

This block sits beside a sample stream and a register-write bus. It keeps a running time for every sample that passes. The time is loaded from the packet sideband when a packet carries a timestamp. Each accepted sample then advances the time by a programmable tick step. Register writes that carry a time and target the one configured address are held in a small command queue. Every other write is forwarded at once on the ordinary write port.

When the sample on the stream has reached or passed the time of the oldest queued command, the block raises a tag bit next to that sample. In the cycle the tagged sample is accepted downstream, the command is popped and strobed out on the timed write port. A downstream register can therefore switch on exactly that sample. Data, last and sideband pass through untouched. The stream path adds no storage and no cycles of latency.

Top module: `timed_cmd_tagger`

## Requirements
- R1: A write with `wr_stb`, `wr_timed` high and `wr_addr` equal to `TAG_ADDR` enters the command queue and never appears on the pass port.
- R2: Every other write appears on `pass_stb`/`pass_addr`/`pass_data` in the cycle after it is presented, with the same address and data.
- R3: The queue holds 2**`QUEUE_LOG2` commands (4 by default). `cmdq_full` is high while it holds that many. A timed write that arrives while it is full is discarded.
- R4: Sideband bit 125 means "has timestamp" and bits 63:0 are the timestamp. The first sample of a packet with bit 125 set takes that timestamp as its time. With bit 125 clear, bits 63:0 are ignored. Bit 124 (end of burst) and all other bits have no effect on timing.
- R5: Each sample after the first of a packet is `tick_step` later than the sample before it. A packet without a timestamp continues counting from the previous packet.
- R6: `m_tag` is high with a valid output sample exactly when the queue is not empty and the oldest command's time is at or before that sample's time. This means a late command tags the very next sample.
- R7: `due_stb` pulses, with `due_addr` = `TAG_ADDR` and the oldest command's data, only in a cycle where a tagged sample is accepted (`m_valid` and `m_ready`). That command then leaves the queue. A stalled tagged sample pops nothing. Commands leave in the order they were written.
- R8: `m_data`, `m_last` and `m_user` equal `s_data`, `s_last` and `s_user`. `m_valid` follows `s_valid`, and `s_ready` follows `m_ready`, in the same cycle.
- R9: `rst_n` low or `clr` high for one clock empties the queue and returns the time tracker to time zero at the start of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of queue and time state |
| tick_step | input | TICK_W | Time advance per accepted sample |
| cmdq_full | output | 1 | Command queue is full |
| wr_stb | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| wr_time | input | TW | Time at which a timed write is due |
| wr_timed | input | 1 | Write carries a time |
| s_data | input | DATA_W | Input sample |
| s_last | input | 1 | Input last beat of packet |
| s_valid | input | 1 | Input valid |
| s_ready | output | 1 | Input ready |
| s_user | input | USER_W | Input per-packet sideband |
| m_data | output | DATA_W | Output sample |
| m_last | output | 1 | Output last beat of packet |
| m_valid | output | 1 | Output valid |
| m_ready | input | 1 | Output ready |
| m_user | output | USER_W | Output sideband |
| m_tag | output | 1 | Timed command is due on this sample |
| pass_stb | output | 1 | Untimed write strobe |
| pass_addr | output | AW | Untimed write address |
| pass_data | output | DW | Untimed write data |
| due_stb | output | 1 | Timed write strobe |
| due_addr | output | AW | Timed write address |
| due_data | output | DW | Timed write data |

## Verification
On every cycle the assertions check four things. A pass-port strobe must trace back to an untimed or foreign write. A full queue must stay unchanged when a write is pushed into it. Time must step by `tick_step` inside a packet. A tag or due strobe must never appear without a queued command and an accepted sample. Only the bench scenarios can show that the tag lands on the right sample index. They also show that headerless packets keep counting, that late commands fire at once and in order, that a stalled tagged sample holds its command, that a write into a full queue is lost, and that a clear really resets time to zero.

// File: rtl/tct_pkg.sv
// Shared constants for the timed command tagger: sideband bit positions.
package tct_pkg;
    localparam int HDR_HAS_TS_BIT = 125;  // sideband flag: packet carries a timestamp
    localparam int HDR_EOB_BIT    = 124;  // sideband flag: end of burst (not used for timing)
    localparam int HDR_TS_LSB     = 0;    // timestamp field starts here
endpackage

// File: rtl/tct_write_router.sv
// Splits register writes: a timed write to TAG_ADDR becomes a queue push
// (combinational), any other write is registered onto the pass port.
// Assumes writes are single-cycle strobes.
module tct_write_router #(
    parameter int          AW       = 8,
    parameter int          DW       = 32,
    parameter logic [AW-1:0] TAG_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_timed,
    output logic          push,
    output logic          pass_stb,
    output logic [AW-1:0] pass_addr,
    output logic [DW-1:0] pass_data
);
    logic is_timed_tag;

    // Decode: timed write aimed at the tagged address.
    always_comb begin
        is_timed_tag = wr_timed && (wr_addr == TAG_ADDR);
        push         = wr_stb && is_timed_tag;
    end

    // Register every other write onto the pass port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_stb  <= 1'b0;
            pass_addr <= '0;
            pass_data <= '0;
        end else begin
            pass_stb <= wr_stb && !is_timed_tag;
            if (wr_stb && !is_timed_tag) begin
                pass_addr <= wr_addr;
                pass_data <= wr_data;
            end
        end
    end

    a_r2_pass_from_untimed: assert property (@(posedge clk) disable iff (!rst_n)
        pass_stb |-> ($past(wr_stb) && !($past(wr_timed) && $past(wr_addr) == TAG_ADDR)));
    a_r1_timed_not_passed: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_timed && wr_addr == TAG_ADDR) |=> !pass_stb);
endmodule

// File: rtl/tct_cmd_queue.sv
// FIFO of timed commands (time, data). Pushes into a full queue are dropped,
// pops from an empty queue are ignored. Head is shown combinationally.
module tct_cmd_queue #(
    parameter int TW   = 64,
    parameter int DW   = 32,
    parameter int LOG2 = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [TW-1:0] push_time,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          empty,
    output logic          full,
    output logic [TW-1:0] head_time,
    output logic [DW-1:0] head_data
);
    localparam int DEPTH = 1 << LOG2;
    localparam int PW    = LOG2 + 1;

    logic [TW-1:0] mem_time [DEPTH];
    logic [DW-1:0] mem_data [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr, fill;
    logic          push_ok, pop_ok;

    // Occupancy and handshake qualification.
    always_comb begin
        fill      = wr_ptr - rd_ptr;
        empty     = (fill == '0);
        full      = (fill == PW'(DEPTH));
        push_ok   = push && !full;
        pop_ok    = pop && !empty;
        head_time = mem_time[rd_ptr[LOG2-1:0]];
        head_data = mem_data[rd_ptr[LOG2-1:0]];
    end

    // Storage write; entries need no reset.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_time[wr_ptr[LOG2-1:0]] <= push_time;
            mem_data[wr_ptr[LOG2-1:0]] <= push_data;
        end
    end

    // Pointer update; reset or clear empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    a_r3_full_drops_push: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (full && $stable(wr_ptr)));
endmodule

// File: rtl/tct_sample_clock.sv
// Tracks the time of the sample currently offered. The first beat of a packet
// takes the header timestamp when present; otherwise time keeps counting.
module tct_sample_clock #(
    parameter int TW     = 64,
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              beat_ok,
    input  logic              beat_last,
    input  logic              hdr_has_ts,
    input  logic [TW-1:0]     hdr_ts,
    input  logic [TICK_W-1:0] tick,
    output logic [TW-1:0]     cur_time
);
    logic          first_q;
    logic [TW-1:0] run_q;

    // Current sample time: header timestamp on the first beat, else running time.
    always_comb cur_time = (first_q && hdr_has_ts) ? hdr_ts : run_q;

    // Advance time on every accepted beat; note packet boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            first_q <= 1'b1;
            run_q   <= '0;
        end else if (beat_ok) begin
            run_q   <= cur_time + TW'(tick);
            first_q <= beat_last;
        end
    end

    a_r5_time_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok && !beat_last && !clr) |=> (cur_time == $past(cur_time) + TW'($past(tick))));
endmodule

// File: rtl/timed_cmd_tagger.sv
// Top: passes the sample stream through, tags the sample at which the oldest
// queued timed write is due, and releases that write when the sample is taken.
// Assumes s_user is held stable for the whole packet.
module timed_cmd_tagger #(
    parameter int            AW         = 8,
    parameter int            DW         = 32,
    parameter int            TW         = 64,
    parameter int            TICK_W     = 16,
    parameter int            DATA_W     = 32,
    parameter int            USER_W     = 128,
    parameter int            QUEUE_LOG2 = 2,
    parameter logic [AW-1:0] TAG_ADDR   = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [TICK_W-1:0] tick_step,
    output logic              cmdq_full,
    input  logic              wr_stb,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [TW-1:0]     wr_time,
    input  logic              wr_timed,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [USER_W-1:0] s_user,
    output logic [DATA_W-1:0] m_data,
    output logic              m_last,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [USER_W-1:0] m_user,
    output logic              m_tag,
    output logic              pass_stb,
    output logic [AW-1:0]     pass_addr,
    output logic [DW-1:0]     pass_data,
    output logic              due_stb,
    output logic [AW-1:0]     due_addr,
    output logic [DW-1:0]     due_data
);
    import tct_pkg::*;

    logic          q_push, q_empty, q_full, take, head_due;
    logic [TW-1:0] head_time, cur_time;
    logic [DW-1:0] head_data;

    tct_write_router #(.AW(AW), .DW(DW), .TAG_ADDR(TAG_ADDR)) router_i (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .wr_timed(wr_timed),
        .push(q_push),
        .pass_stb(pass_stb), .pass_addr(pass_addr), .pass_data(pass_data)
    );

    tct_cmd_queue #(.TW(TW), .DW(DW), .LOG2(QUEUE_LOG2)) queue_i (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push(q_push), .push_time(wr_time), .push_data(wr_data),
        .pop(due_stb),
        .empty(q_empty), .full(q_full),
        .head_time(head_time), .head_data(head_data)
    );

    tct_sample_clock #(.TW(TW), .TICK_W(TICK_W)) clock_i (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .beat_ok(take), .beat_last(s_last),
        .hdr_has_ts(s_user[HDR_HAS_TS_BIT]),
        .hdr_ts(s_user[HDR_TS_LSB +: TW]),
        .tick(tick_step),
        .cur_time(cur_time)
    );

    // Stream pass-through and tag / timed-write release.
    always_comb begin
        m_data    = s_data;
        m_last    = s_last;
        m_user    = s_user;
        m_valid   = s_valid;
        s_ready   = m_ready;
        take      = s_valid && m_ready;
        head_due  = !q_empty && (head_time <= cur_time);
        m_tag     = s_valid && head_due;
        due_stb   = take && head_due;
        due_addr  = TAG_ADDR;
        due_data  = head_data;
        cmdq_full = q_full;
    end

    a_r6_tag_needs_command: assert property (@(posedge clk) disable iff (!rst_n)
        m_tag |-> (m_valid && !q_empty));
    a_r7_due_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        due_stb |-> (m_valid && m_ready && m_tag));
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> q_empty);
endmodule

// File: tb/timed_cmd_tagger_tb_top.sv
`timescale 1ns/100ps
module timed_cmd_tagger_tb_top;
    localparam int AW = 8, DW = 32, TW = 64, TICK_W = 16, DATA_W = 32, USER_W = 128;
    localparam int QLOG2 = 2;
    localparam int QDEPTH = 1 << QLOG2;
    localparam logic [AW-1:0] TAG = 8'h10;

    logic clk = 1'b0;
    logic rst_n = 1'b0, clr = 1'b0;
    logic [TICK_W-1:0] tick_step = 16'd1;
    logic cmdq_full;
    logic wr_stb = 1'b0, wr_timed = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [TW-1:0] wr_time = '0;
    logic [DATA_W-1:0] s_data = '0;
    logic s_last = 1'b0, s_valid = 1'b0, s_ready;
    logic [USER_W-1:0] s_user = '0;
    logic [DATA_W-1:0] m_data;
    logic m_last, m_valid, m_tag;
    logic m_ready = 1'b1;
    logic [USER_W-1:0] m_user;
    logic pass_stb, due_stb;
    logic [AW-1:0] pass_addr, due_addr;
    logic [DW-1:0] pass_data, due_data;

    always #2.5 clk = ~clk;

    timed_cmd_tagger #(.AW(AW), .DW(DW), .TW(TW), .TICK_W(TICK_W), .DATA_W(DATA_W),
                       .USER_W(USER_W), .QUEUE_LOG2(QLOG2), .TAG_ADDR(TAG)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick_step(tick_step), .cmdq_full(cmdq_full),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .wr_time(wr_time), .wr_timed(wr_timed),
        .s_data(s_data), .s_last(s_last), .s_valid(s_valid), .s_ready(s_ready), .s_user(s_user),
        .m_data(m_data), .m_last(m_last), .m_valid(m_valid), .m_ready(m_ready), .m_user(m_user),
        .m_tag(m_tag), .pass_stb(pass_stb), .pass_addr(pass_addr), .pass_data(pass_data),
        .due_stb(due_stb), .due_addr(due_addr), .due_data(due_data)
    );

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [DATA_W-1:0] d;
        logic              l;
        logic [USER_W-1:0] u;
        logic              t;
        logic [DW-1:0]     dd;
    } exp_t;
    exp_t exp_q[$];

    // Reference model built from the requirements.
    logic [TW-1:0] mq_time[$];
    logic [DW-1:0] mq_data[$];
    logic [TW-1:0] model_run = '0;
    bit            model_first = 1'b1;

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [USER_W-1:0] mk_user(input bit has, input bit eob, input logic [TW-1:0] ts);
        mk_user = '0;
        mk_user[125] = has;
        mk_user[124] = eob;
        mk_user[123:64] = 60'h5A5_0F0F_3C3C_A5A5;
        mk_user[63:0] = ts;
    endfunction

    // Register write, with model update and pass-port check (R1, R2).
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [TW-1:0] t, input bit timed);
        bit to_q;
        to_q = timed && (a == TAG);
        @(posedge clk); #1;
        wr_stb = 1'b1; wr_addr = a; wr_data = d; wr_time = t; wr_timed = timed;
        @(posedge clk); #1;
        wr_stb = 1'b0; wr_timed = 1'b0;
        if (to_q && mq_time.size() < QDEPTH) begin  // R3: full queue drops
            mq_time.push_back(t);
            mq_data.push_back(d);
        end
        @(negedge clk);
        if (to_q)
            check(pass_stb == 1'b0, "R1 timed write leaked to pass port", pass_stb, 0);
        else
            check(pass_stb && pass_addr == a && pass_data == d, "R2 pass port",
                  {pass_stb, pass_addr, pass_data}, {1'b1, a, d});
    endtask

    // Offer one beat; compute expected tag from the model (R4..R8).
    task automatic put_beat(input logic [DATA_W-1:0] d, input bit last, input logic [USER_W-1:0] u, input int stall);
        exp_t e;
        logic [TW-1:0] cur;
        cur = (model_first && u[125]) ? u[63:0] : model_run;
        e.d = d; e.l = last; e.u = u;
        e.t = (mq_time.size() != 0) && (mq_time[0] <= cur);
        e.dd = e.t ? mq_data[0] : '0;
        if (e.t) begin
            void'(mq_time.pop_front());
            void'(mq_data.pop_front());
        end
        model_run = cur + TW'(tick_step);
        model_first = last;
        exp_q.push_back(e);
        @(posedge clk); #1;
        s_valid = 1'b1; s_data = d; s_last = last; s_user = u;
        if (stall > 0) begin
            m_ready = 1'b0;
            for (int k = 0; k < stall; k++) begin @(posedge clk); #1; end
            m_ready = 1'b1;
        end
        @(posedge clk); #1;
        s_valid = 1'b0;
    endtask

    task automatic put_pkt(input int n, input bit has, input logic [TW-1:0] ts, input bit eob,
                           input logic [DATA_W-1:0] base, input int stall_idx);
        for (int i = 0; i < n; i++)
            put_beat(base + DATA_W'(i), i == n - 1, mk_user(has, eob, ts), (i == stall_idx) ? 2 : 0);
    endtask

    task automatic model_clear();
        mq_time.delete(); mq_data.delete();
        model_run = '0; model_first = 1'b1;
    endtask

    // Monitor: compare each accepted beat with the scoreboard; watch stalls.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && m_valid && !m_ready)
                check(due_stb == 1'b0, "R7 due strobe during stall", due_stb, 0);
            if (rst_n && m_valid && m_ready) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected output beat", m_data, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(m_data == e.d && m_last == e.l && m_user == e.u && s_ready,
                          "R8 pass-through", {m_data, m_last, m_user}, {e.d, e.l, e.u});
                    check(m_tag == e.t && due_stb == e.t, "R6 tag position",
                          {m_tag, due_stb}, {e.t, e.t});
                    if (e.t)
                        check(due_addr == TAG && due_data == e.dd, "R7 timed write contents",
                              {due_addr, due_data}, {TAG, e.dd});
                end
            end
        end
    end

    initial begin
        #(5ns * 20000);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(!m_valid && !cmdq_full && !due_stb && !pass_stb && !m_tag, "R9 reset state",
              {m_valid, cmdq_full, due_stb, pass_stb, m_tag}, 0);

        // R1, R2: write routing
        do_write(TAG, 32'h1111_0001, 64'd0, 1'b0);      // untimed to tag address
        do_write(8'h22, 32'h2222_0002, 64'd5, 1'b1);    // timed, other address
        do_write(8'h33, 32'h3333_0003, 64'd0, 1'b0);

        // R4, R6: tag lands on sample at time 105 (index 5)
        do_write(TAG, 32'hA000_0105, 64'd105, 1'b1);
        put_pkt(8, 1'b1, 64'd100, 1'b0, 32'h100, -1);
        // R5: headerless packet continues at 108; command at 109 -> index 1
        do_write(TAG, 32'hA000_0109, 64'd109, 1'b1);
        put_pkt(4, 1'b0, 64'hDEAD_BEEF, 1'b0, 32'h200, -1);

        // R6, R7: two late commands tag the first two samples in order
        do_write(TAG, 32'hB000_0010, 64'd10, 1'b1);
        do_write(TAG, 32'hB000_0020, 64'd20, 1'b1);
        put_pkt(3, 1'b1, 64'd200, 1'b1, 32'h300, -1);

        // R7: stall on the tagged sample
        do_write(TAG, 32'hC000_0302, 64'd302, 1'b1);
        put_pkt(4, 1'b1, 64'd300, 1'b0, 32'h400, 2);

        // R5: tick step of 3, command at 412 -> index 4
        tick_step = 16'd3;
        do_write(TAG, 32'hD000_0412, 64'd412, 1'b1);
        put_pkt(6, 1'b1, 64'd400, 1'b0, 32'h500, -1);
        tick_step = 16'd1;

        // R3: fill queue, overflow write dropped
        for (int i = 0; i < QDEPTH; i++)
            do_write(TAG, 32'hE000_0000 + DW'(i), 64'd1000 + TW'(i), 1'b1);
        @(negedge clk);
        check(cmdq_full == 1'b1, "R3 full flag", cmdq_full, 1);
        do_write(TAG, 32'hEEEE_FFFF, 64'd1000, 1'b1);
        @(negedge clk);
        check(cmdq_full == 1'b1, "R3 full after dropped write", cmdq_full, 1);
        put_pkt(6, 1'b1, 64'd1000, 1'b0, 32'h600, -1);
        @(negedge clk);
        check(cmdq_full == 1'b0, "R3 full flag clears", cmdq_full, 0);

        // R9: clear drops a stale command and restarts time at zero
        do_write(TAG, 32'hBAD0_0000, 64'd0, 1'b1);
        @(posedge clk); #1 clr = 1'b1;
        @(posedge clk); #1 clr = 1'b0;
        model_clear();
        put_pkt(3, 1'b0, 64'd77, 1'b1, 32'h700, -1);     // times 0..2, no tag
        do_write(TAG, 32'hF000_0004, 64'd4, 1'b1);
        put_pkt(3, 1'b0, 64'd0, 1'b1, 32'h800, -1);      // times 3..5, tag index 1

        repeat (3) @(posedge clk);
        check(exp_q.size() == 0, "R8 all beats delivered", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule